// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the host-side master for a 16-clock serial analog-to-digital converter. For each frame it lowers chip select and drives SCLK from a simple divider of the system clock. It shifts in the converter's sixteen response bits and returns the 12-bit result together with a one-cycle valid strobe. The converter's power is steered only by how many SCLK falling edges pass before chip select is released. A frame released after the 4th falling edge puts the converter to sleep. A full 16-edge frame keeps it awake, or wakes it when it was asleep.

Software, or a sequencer, issues one of four commands while `busy` is low: convert, convert and then sleep, sleep, or wake. The controller keeps its own record of whether the converter is awake. A convert command that arrives while the converter sleeps is preceded by a wake frame. The data from that frame is dropped, and the controller then waits the wake-up delay before the real conversion. When `auto_en` is held high and no command is offered, the controller runs conversions back to back. The quiet time between frames is always respected. A result whose four leading bits are not all zero is flagged as a framing error.

Top module: `sadc_host`

## Requirements
- R1: During and after reset, `cs_n` is 1, `sclk` is 1, `busy` is 0 and `res_valid` is 0.
- R2: A conversion frame holds `cs_n` at 0 for exactly 16 SCLK falling edges. `sclk` rests at 1 whenever `cs_n` is 1. The converter presents response bit k (k = 1..16, most significant first) after the k-th falling edge, and the controller samples it on the next rising edge.
- R3: At the end of a conversion frame, `res_data` holds the 12 least significant response bits and `res_valid` is 1 for exactly one cycle. That cycle is the one in which `cs_n` has just returned to 1.
- R4: `res_err` is 1 together with `res_valid` when any of the 4 leading response bits is 1. It is 0 when all four are 0, and it is never 1 without `res_valid`.
- R5: Command code 2 (sleep) on an awake converter issues a frame released right after the 4th SCLK falling edge, produces no result, and marks the converter asleep.
- R6: Command code 0 (convert) on a sleeping converter first issues a 16-edge wake frame whose data produces no `res_valid`. `cs_n` then stays at 1 for at least WAKE_CYC cycles, and a conversion frame with a valid result follows.
- R7: Command code 3 (wake) on a sleeping converter issues one 16-edge frame with no result. On an awake converter it issues no frame.
- R8: Command code 2 (sleep) on a converter that is already asleep issues no frame.
- R9: Command code 1 (convert then sleep) issues a conversion frame with its result, followed by a 4-edge sleep frame.
- R10: Between any two frames, `cs_n` stays at 1 for at least QUIET_CYC cycles.
- R11: `busy` is 1 from the cycle after a command is accepted until its last frame and gap have finished. A command offered while `busy` is 1 is ignored.
- R12: While `auto_en` is 1 and no command is offered, the controller runs back-to-back conversions, each returning a valid result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered; taken when `busy` is 0 |
| cmd_op | input | 2 | 0 convert, 1 convert then sleep, 2 sleep, 3 wake |
| auto_en | input | 1 | Burst mode: convert repeatedly while idle |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter, rests high |
| res_data | output | 12 | Last conversion result |
| res_valid | output | 1 | One-cycle strobe for a new result |
| res_err | output | 1 | Leading bits were not zero (with `res_valid`) |
| busy | output | 1 | Controller is running a frame sequence |

## Verification
Some rules hold on every cycle and are checked by assertions. SCLK rests high while chip select is high. Every frame ends after either 4 or 16 falling edges. Chip select stays high for the quiet time between frames. `busy` stays asserted while chip select is low. A result strobe lasts one cycle, arrives only as chip select rises, and never follows a 4-edge frame. Other behaviour depends on the power state and on data, so only the bench scenarios can show it. This covers the automatic wake frame and its discarded data, the wake delay, sleep and wake commands being ignored when they have nothing to do, the convert-then-sleep pair, correct result bits and the framing flag, and burst mode.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int FRAME_EDGES = 16;
  localparam int LEAD_BITS   = 4;
  localparam int DATA_BITS   = 12;
  localparam int SLEEP_EDGES = 4;
  localparam int CNT_W       = $clog2(FRAME_EDGES + 1);

  typedef enum logic [1:0] {
    OP_CONV       = 2'd0,
    OP_CONV_SLEEP = 2'd1,
    OP_SLEEP      = 2'd2,
    OP_WAKE       = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    FK_CONV  = 2'd0,
    FK_DUMMY = 2'd1,
    FK_SLEEP = 2'd2
  } kind_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } state_e;
endpackage

// File: rtl/sadc_rst_sync.sv
module sadc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/sadc_sclk_gen.sv
module sadc_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic fall_tick,
  output logic rise_tick
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          wrap;

  assign wrap = (cnt_q == DW'(HALF_DIV - 1));

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b1;
    end else if (wrap) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk      = sclk_q;
  assign fall_tick = run & wrap &  sclk_q;
  assign rise_tick = run & wrap & ~sclk_q;
endmodule

// File: rtl/sadc_frame_rx.sv
module sadc_frame_rx
  import sadc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   fall_tick,
  input  logic                   rise_tick,
  input  logic                   sdata,
  output logic [CNT_W-1:0]       fall_cnt,
  output logic [FRAME_EDGES-1:0] word_nxt
);
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [FRAME_EDGES-1:0] sh_q, sh_d;

  assign word_nxt = {sh_q[FRAME_EDGES-2:0], sdata};

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (clear) begin
      cnt_d = '0;
      sh_d  = '0;
    end else begin
      if (fall_tick) cnt_d = cnt_q + CNT_W'(1);
      if (rise_tick) sh_d  = word_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign fall_cnt = cnt_q;
endmodule

// File: rtl/sadc_host.sv
module sadc_host
  import sadc_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int QUIET_CYC = 6,
  parameter int WAKE_CYC  = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic                 auto_en,
  input  logic                 sdata,
  output logic                 cs_n,
  output logic                 sclk,
  output logic [DATA_BITS-1:0] res_data,
  output logic                 res_valid,
  output logic                 res_err,
  output logic                 busy
);
  localparam int GAP_MAX = (WAKE_CYC > QUIET_CYC) ? WAKE_CYC : QUIET_CYC;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  logic rst_s_n;

  state_e st_q, st_d;
  kind_e  kind_q, kind_d;
  logic   pend_conv_q, pend_conv_d;
  logic   pend_sleep_q, pend_sleep_d;
  logic   awake_q, awake_d;
  logic   cs_n_q, cs_n_d;
  logic [GAP_W-1:0]     gap_q, gap_d;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic   valid_q, valid_d;
  logic   err_q, err_d;

  logic                   run, fall_tick, rise_tick, rx_clear, frame_done;
  logic [CNT_W-1:0]       fall_cnt, end_edges;
  logic [FRAME_EDGES-1:0] word_nxt;

  sadc_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  sadc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .run       (run),
    .sclk      (sclk),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick)
  );

  sadc_frame_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clear     (rx_clear),
    .fall_tick (fall_tick),
    .rise_tick (rise_tick),
    .sdata     (sdata),
    .fall_cnt  (fall_cnt),
    .word_nxt  (word_nxt)
  );

  assign run        = (st_q == ST_FRAME);
  assign end_edges  = (kind_q == FK_SLEEP) ? CNT_W'(SLEEP_EDGES) : CNT_W'(FRAME_EDGES);
  assign frame_done = run && rise_tick && (fall_cnt == end_edges);

  always_comb begin
    st_d         = st_q;
    kind_d       = kind_q;
    pend_conv_d  = pend_conv_q;
    pend_sleep_d = pend_sleep_q;
    awake_d      = awake_q;
    cs_n_d       = cs_n_q;
    gap_d        = gap_q;
    data_d       = data_q;
    valid_d      = 1'b0;
    err_d        = 1'b0;
    rx_clear     = 1'b0;

    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid || auto_en) begin
          op_e op;
          op = cmd_valid ? op_e'(cmd_op) : OP_CONV;
          unique case (op)
            OP_CONV, OP_CONV_SLEEP: begin
              st_d     = ST_FRAME;
              cs_n_d   = 1'b0;
              rx_clear = 1'b1;
              pend_sleep_d = (op == OP_CONV_SLEEP);
              if (awake_q) begin
                kind_d = FK_CONV;
              end else begin
                kind_d      = FK_DUMMY;
                pend_conv_d = 1'b1;
              end
            end
            OP_SLEEP: begin
              if (awake_q) begin
                st_d     = ST_FRAME;
                cs_n_d   = 1'b0;
                rx_clear = 1'b1;
                kind_d   = FK_SLEEP;
              end
            end
            OP_WAKE: begin
              if (!awake_q) begin
                st_d     = ST_FRAME;
                cs_n_d   = 1'b0;
                rx_clear = 1'b1;
                kind_d   = FK_DUMMY;
              end
            end
            default: ;
          endcase
        end
      end
      ST_FRAME: begin
        if (frame_done) begin
          st_d    = ST_GAP;
          cs_n_d  = 1'b1;
          awake_d = (kind_q != FK_SLEEP);
          gap_d   = (kind_q == FK_DUMMY) ? GAP_W'(WAKE_CYC - 1) : GAP_W'(QUIET_CYC - 1);
          if (kind_q == FK_CONV) begin
            data_d  = word_nxt[DATA_BITS-1:0];
            valid_d = 1'b1;
            err_d   = |word_nxt[FRAME_EDGES-1:FRAME_EDGES-LEAD_BITS];
          end
        end
      end
      ST_GAP: begin
        if (gap_q != '0) begin
          gap_d = gap_q - GAP_W'(1);
        end else if (pend_conv_q) begin
          st_d        = ST_FRAME;
          cs_n_d      = 1'b0;
          rx_clear    = 1'b1;
          kind_d      = FK_CONV;
          pend_conv_d = 1'b0;
        end else if (pend_sleep_q) begin
          st_d         = ST_FRAME;
          cs_n_d       = 1'b0;
          rx_clear     = 1'b1;
          kind_d       = FK_SLEEP;
          pend_sleep_d = 1'b0;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q         <= ST_IDLE;
      kind_q       <= FK_CONV;
      pend_conv_q  <= 1'b0;
      pend_sleep_q <= 1'b0;
      awake_q      <= 1'b1;
      cs_n_q       <= 1'b1;
      gap_q        <= '0;
      valid_q      <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      st_q         <= st_d;
      kind_q       <= kind_d;
      pend_conv_q  <= pend_conv_d;
      pend_sleep_q <= pend_sleep_d;
      awake_q      <= awake_d;
      cs_n_q       <= cs_n_d;
      gap_q        <= gap_d;
      valid_q      <= valid_d;
      err_q        <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)     data_q <= '0;
    else if (valid_d) data_q <= data_d;
  end

  assign cs_n      = cs_n_q;
  assign res_data  = data_q;
  assign res_valid = valid_q;
  assign res_err   = err_q;
  assign busy      = (st_q != ST_IDLE);
endmodule

// File: rtl/sadc_host_chk.sv
module sadc_host_chk #(
  parameter int QUIET_CYC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic busy,
  input logic res_valid,
  input logic res_err
);
  localparam int HW = $clog2(QUIET_CYC + 1);

  logic [HW-1:0] hi_cnt;
  logic [4:0]    fcnt;
  logic          sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= HW'(QUIET_CYC);
      fcnt   <= '0;
      sclk_d <= 1'b1;
    end else begin
      sclk_d <= sclk;
      if (!cs_n)                        hi_cnt <= '0;
      else if (hi_cnt != HW'(QUIET_CYC)) hi_cnt <= hi_cnt + HW'(1);
      if (cs_n)                fcnt <= '0;
      else if (sclk_d && !sclk) fcnt <= fcnt + 5'd1;
    end
  end

  a_r2_sclk_rests_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  a_r2_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> (fcnt == 5'd4 || fcnt == 5'd16));

  a_r3_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (cs_n && !$past(cs_n)));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  a_r4_err_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> res_valid);

  a_r5_no_result_short: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && fcnt == 5'd4) |-> !res_valid);

  a_r10_quiet_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt == HW'(QUIET_CYC)));

  a_r11_busy_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);
endmodule

bind sadc_host sadc_host_chk #(.QUIET_CYC(QUIET_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .busy      (busy),
  .res_valid (res_valid),
  .res_err   (res_err)
);

// File: tb/sadc_host_tb.sv
module sadc_host_tb;
  localparam int QUIET = 6;
  localparam int WAKE  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic auto_en = 1'b0;
  logic sdata = 1'b0;
  logic cs_n, sclk, res_valid, res_err, busy;
  logic [11:0] res_data;

  always #5 clk = ~clk;

  sadc_host #(.HALF_DIV(2), .QUIET_CYC(QUIET), .WAKE_CYC(WAKE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .auto_en(auto_en), .sdata(sdata), .cs_n(cs_n), .sclk(sclk),
    .res_data(res_data), .res_valid(res_valid), .res_err(res_err), .busy(busy)
  );

  int checks = 0;
  int failures = 0;

  // converter model: bit k after k-th falling edge, MSB first
  logic [15:0] adc_word = 16'h0000;
  int bitk = 0;
  always @(negedge cs_n) begin bitk = 0; sdata = 1'b0; end
  always @(negedge sclk) begin
    if (!cs_n && bitk < 16) begin
      bitk = bitk + 1;
      sdata = adc_word[16 - bitk];
    end
  end

  // monitor at negedge clk
  int nfr = 0, nres = 0, hi = 0, edges = 0;
  int fr_edges [256];
  int fr_gap [256];
  logic [11:0] r_data [256];
  logic r_err [256];
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  always @(negedge clk) begin
    if (cs_n) begin
      if (!prev_cs && nfr < 256) begin fr_edges[nfr] = edges; nfr = nfr + 1; end
      hi = hi + 1;
    end else begin
      if (prev_cs) begin
        if (nfr < 256) fr_gap[nfr] = hi;
        edges = 0;
      end
      hi = 0;
      if (prev_sclk && !sclk) edges = edges + 1;
    end
    if (res_valid && nres < 256) begin
      r_data[nres] = res_data; r_err[nres] = res_err; nres = nres + 1;
    end
    prev_cs = cs_n; prev_sclk = sclk;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ge(input string req, input int act, input int lim);
    checks++;
    if (act < lim) begin
      failures++;
      $display("FAIL %s actual=%0d expected>=%0d", req, act, lim);
    end
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op);
    @(negedge clk);
    while (busy) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // {word, expected framing error}
  localparam logic [16:0] VEC [6] = '{
    {16'h0ABC, 1'b0}, {16'h0FFF, 1'b0}, {16'h0000, 1'b0},
    {16'h8123, 1'b1}, {16'h1555, 1'b1}, {16'h0800, 1'b0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int f0, r0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 cs_n in reset", cs_n, 1); chk("R1 sclk in reset", sclk, 1);
    chk("R1 busy in reset", busy, 0); chk("R1 valid in reset", res_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 cs_n after reset", cs_n, 1); chk("R1 busy after reset", busy, 0);

    // table walk: R2 R3 R4 R10
    for (int i = 0; i < 6; i++) begin
      adc_word = VEC[i][16:1];
      f0 = nfr; r0 = nres;
      send(2'd0);
      chk("R2 frames", nfr - f0, 1);
      chk("R2 edges", fr_edges[f0], 16);
      chk("R3 results", nres - r0, 1);
      chk("R3 data", int'(r_data[r0]), int'(VEC[i][12:1]));
      chk("R4 err", int'(r_err[r0]), int'(VEC[i][0]));
      if (i > 0) chk_ge("R10 quiet", fr_gap[f0], QUIET);
    end

    // R5 sleep
    adc_word = 16'h0123;
    f0 = nfr; r0 = nres;
    send(2'd2);
    chk("R5 frames", nfr - f0, 1); chk("R5 edges", fr_edges[f0], 4);
    chk("R5 no result", nres - r0, 0);

    // R8 sleep while asleep
    f0 = nfr; send(2'd2);
    chk("R8 no frame", nfr - f0, 0);

    // R6 convert while asleep
    adc_word = 16'h0456;
    f0 = nfr; r0 = nres;
    send(2'd0);
    chk("R6 frames", nfr - f0, 2);
    chk("R6 wake edges", fr_edges[f0], 16);
    chk("R6 conv edges", fr_edges[f0+1], 16);
    chk_ge("R6 wake delay", fr_gap[f0+1], WAKE);
    chk("R6 one result", nres - r0, 1);
    chk("R6 data", int'(r_data[r0]), 'h456);

    // R7 wake
    send(2'd2);
    f0 = nfr; r0 = nres;
    send(2'd3);
    chk("R7 wake frames", nfr - f0, 1); chk("R7 wake edges", fr_edges[f0], 16);
    chk("R7 no result", nres - r0, 0);
    f0 = nfr; send(2'd3);
    chk("R7 awake ignored", nfr - f0, 0);

    // R9 convert then sleep
    adc_word = 16'h0789;
    f0 = nfr; r0 = nres;
    send(2'd1);
    chk("R9 frames", nfr - f0, 2);
    chk("R9 conv edges", fr_edges[f0], 16); chk("R9 sleep edges", fr_edges[f0+1], 4);
    chk("R9 result", nres - r0, 1); chk("R9 data", int'(r_data[r0]), 'h789);
    chk_ge("R10 quiet before sleep", fr_gap[f0+1], QUIET);
    send(2'd3);

    // R11 busy and ignored command
    adc_word = 16'h0321;
    f0 = nfr;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R11 busy after accept", busy, 1);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    chk("R11 ignored while busy", nfr - f0, 1);
    chk("R11 idle after", busy, 0);

    // R12 burst
    adc_word = 16'h0A5A;
    f0 = nfr; r0 = nres;
    auto_en = 1'b1;
    while (nres < r0 + 3) @(negedge clk);
    auto_en = 1'b0;
    wait_idle();
    chk_ge("R12 burst results", nres - r0, 3);
    for (int k = 0; k < 3; k++) chk("R12 burst data", int'(r_data[r0+k]), 'hA5A);
    chk_ge("R12 burst gap", fr_gap[f0+1], QUIET);
    chk("R12 stops when idle", busy, 0);

    summary();
  end
endmodule